// File: doc/BRIEF.md
# Load/Store Byte-Lane Aligner

This block sits between a 32-bit core datapath and a byte-addressed, little-endian 32-bit data memory port. On the store side it takes the low address bits, an access size and the register value. It returns a memory write word with the value copied into every lane the size could use, and a per-lane byte-enable mask, so that only the addressed byte or halfword of the word changes in memory.

On the load side it takes the raw word returned by a synchronous-read memory, together with the low address bits, the size and a signed/unsigned flag captured with the request. One clock later it returns the addressed lanes moved down to bit 0 and extended to the full width, with a valid strobe. Both paths check the alignment for the access size and raise a misalignment flag. A misaligned store has all its byte enables cleared. A misaligned load returns zero.

Top module: `lsa_lane_aligner`

## Requirements
- R1: With size code 00 (byte), the store word carries data bits 7:0 in all four lanes, and the byte enable is one-hot at bit addr_lo. Lane i is word bits 8i+7:8i, and the lowest address is lane 0.
- R2: With size code 01 (halfword), the store word carries data bits 15:0 in both halves. The byte enable is 0011 when addr_lo is 0 and 1100 when addr_lo is 2.
- R3: With size code 10 or 11 (word), the store word equals the store data and the byte enable is 1111.
- R4: A halfword access with addr_lo bit 0 set, or a word access with addr_lo not 00, is misaligned. Byte accesses are never misaligned. A misaligned store raises st_misalign and drives the byte enable to 0000.
- R5: A byte load returns memory lane addr_lo in result bits 7:0. When ld_signed is 1, bit 7 of that byte fills bits 31:8. When ld_signed is 0, zeros fill them.
- R6: A halfword load returns memory bits 15:0 for addr_lo 0 and bits 31:16 for addr_lo 2. When ld_signed is 1, bit 15 of that halfword fills bits 31:16. When ld_signed is 0, zeros fill them.
- R7: A word load returns the memory word unchanged, and ld_signed has no effect.
- R8: Load results appear one cycle after the request. ld_valid is high exactly in the cycle after a cycle with ld_req high. In a cycle with no request, ld_result and ld_misalign keep their values. A misaligned load raises ld_misalign and returns zero.
- R9: While rst_n is low, ld_valid, ld_result and ld_misalign are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_addr_lo | input | 2 | Low address bits of the store |
| st_size | input | 2 | Store size: 00 byte, 01 halfword, 1x word |
| st_data | input | 32 | Register value to store |
| st_wdata | output | 32 | Lane-replicated write word |
| st_be | output | 4 | Byte enables, bit i for lane i |
| st_misalign | output | 1 | Store alignment violation |
| ld_req | input | 1 | Load request, memory word present this cycle |
| ld_addr_lo | input | 2 | Low address bits of the load |
| ld_size | input | 2 | Load size: 00 byte, 01 halfword, 1x word |
| ld_signed | input | 1 | 1 sign-extends, 0 zero-extends |
| ld_rdata | input | 32 | Raw word from memory |
| ld_valid | output | 1 | Load result valid |
| ld_result | output | 32 | Extracted and extended load value |
| ld_misalign | output | 1 | Load alignment violation, registered |

## Verification
Assertions check the following on every cycle:
- Misaligned stores never enable a lane.
- A byte store enables exactly one lane.
- An aligned word store passes data and all enables through.
- The valid strobe follows the request by one cycle.
- A misaligned load result is zero.
- Signed byte results carry a uniform upper field.
- Idle cycles hold the load outputs.

Only the bench's scenarios can show lane selection for each offset, the choice between sign and zero extension against known memory patterns, and the reset values. The bench sweeps every size, offset and signedness over sign-bit patterns, then applies random traffic against its own model.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
    typedef enum logic [1:0] {
        ACC_BYTE  = 2'b00,
        ACC_HALF  = 2'b01,
        ACC_WORD  = 2'b10,
        ACC_WORDX = 2'b11
    } acc_size_e;
endpackage

// File: rtl/lsa_align_check.sv
module lsa_align_check
    import lsa_pkg::*;
#(
    parameter int OFS_W = 2
) (
    input  logic [OFS_W-1:0] addr_lo,
    input  acc_size_e        size,
    output logic             misalign
);
    always_comb begin
        unique case (size)
            ACC_BYTE:  misalign = 1'b0;
            ACC_HALF:  misalign = addr_lo[0];
            ACC_WORD,
            ACC_WORDX: misalign = |addr_lo;
            default:   misalign = 1'b0;
        endcase
    end
endmodule

// File: rtl/lsa_store_lanes.sv
module lsa_store_lanes
    import lsa_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int NUM_LANES = DATA_W / 8,
    localparam int OFS_W = $clog2(NUM_LANES)
) (
    input  logic [OFS_W-1:0]     addr_lo,
    input  acc_size_e            size,
    input  logic [DATA_W-1:0]    data,
    input  logic                 misalign,
    output logic [DATA_W-1:0]    wdata,
    output logic [NUM_LANES-1:0] be
);
    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        localparam int HSEL = i % 2;
        localparam int HIDX = i / 2;
        always_comb begin
            unique case (size)
                ACC_BYTE: begin
                    wdata[i*8 +: 8] = data[7:0];
                    be[i] = (addr_lo == OFS_W'(i));
                end
                ACC_HALF: begin
                    wdata[i*8 +: 8] = data[HSEL*8 +: 8];
                    be[i] = (addr_lo[OFS_W-1:1] == (OFS_W-1)'(HIDX));
                end
                default: begin
                    wdata[i*8 +: 8] = data[i*8 +: 8];
                    be[i] = 1'b1;
                end
            endcase
            if (misalign) be[i] = 1'b0;
        end
    end
endmodule

// File: rtl/lsa_load_extract.sv
module lsa_load_extract
    import lsa_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int NUM_LANES = DATA_W / 8,
    localparam int OFS_W = $clog2(NUM_LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [OFS_W-1:0]  addr_lo,
    input  acc_size_e         size,
    input  logic              sgn,
    input  logic [DATA_W-1:0] rdata,
    input  logic              misalign,
    output logic              valid_q,
    output logic [DATA_W-1:0] result_q,
    output logic              misalign_q
);
    logic [DATA_W-1:0] shifted;
    logic [DATA_W-1:0] ext;

    assign shifted = rdata >> {addr_lo, 3'b000};

    always_comb begin
        unique case (size)
            ACC_BYTE: ext = {{(DATA_W-8){sgn & shifted[7]}}, shifted[7:0]};
            ACC_HALF: ext = {{(DATA_W-16){sgn & shifted[15]}}, shifted[15:0]};
            default:  ext = rdata;
        endcase
        if (misalign) ext = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q    <= 1'b0;
            result_q   <= '0;
            misalign_q <= 1'b0;
        end else begin
            valid_q <= req;
            if (req) begin
                result_q   <= ext;
                misalign_q <= misalign;
            end
        end
    end
endmodule

// File: rtl/lsa_lane_aligner.sv
module lsa_lane_aligner
    import lsa_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int NUM_LANES = DATA_W / 8,
    localparam int OFS_W = $clog2(NUM_LANES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [OFS_W-1:0]     st_addr_lo,
    input  logic [1:0]           st_size,
    input  logic [DATA_W-1:0]    st_data,
    output logic [DATA_W-1:0]    st_wdata,
    output logic [NUM_LANES-1:0] st_be,
    output logic                 st_misalign,
    input  logic                 ld_req,
    input  logic [OFS_W-1:0]     ld_addr_lo,
    input  logic [1:0]           ld_size,
    input  logic                 ld_signed,
    input  logic [DATA_W-1:0]    ld_rdata,
    output logic                 ld_valid,
    output logic [DATA_W-1:0]    ld_result,
    output logic                 ld_misalign
);
    acc_size_e st_sz;
    acc_size_e ld_sz;
    logic      ld_mis_c;

    assign st_sz = acc_size_e'(st_size);
    assign ld_sz = acc_size_e'(ld_size);

    lsa_align_check #(.OFS_W(OFS_W)) u_st_chk (
        .addr_lo (st_addr_lo),
        .size    (st_sz),
        .misalign(st_misalign)
    );

    lsa_align_check #(.OFS_W(OFS_W)) u_ld_chk (
        .addr_lo (ld_addr_lo),
        .size    (ld_sz),
        .misalign(ld_mis_c)
    );

    lsa_store_lanes #(.DATA_W(DATA_W)) u_store (
        .addr_lo (st_addr_lo),
        .size    (st_sz),
        .data    (st_data),
        .misalign(st_misalign),
        .wdata   (st_wdata),
        .be      (st_be)
    );

    lsa_load_extract #(.DATA_W(DATA_W)) u_load (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (ld_req),
        .addr_lo   (ld_addr_lo),
        .size      (ld_sz),
        .sgn       (ld_signed),
        .rdata     (ld_rdata),
        .misalign  (ld_mis_c),
        .valid_q   (ld_valid),
        .result_q  (ld_result),
        .misalign_q(ld_misalign)
    );
endmodule

// File: rtl/lsa_lane_aligner_chk.sv
module lsa_lane_aligner_chk #(
    parameter int DATA_W = 32,
    localparam int NUM_LANES = DATA_W / 8,
    localparam int OFS_W = $clog2(NUM_LANES)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [1:0]           st_size,
    input logic [DATA_W-1:0]    st_data,
    input logic [DATA_W-1:0]    st_wdata,
    input logic [NUM_LANES-1:0] st_be,
    input logic                 st_misalign,
    input logic                 ld_req,
    input logic [1:0]           ld_size,
    input logic                 ld_signed,
    input logic                 ld_valid,
    input logic [DATA_W-1:0]    ld_result,
    input logic                 ld_misalign
);
    a_r4_no_enable_when_misaligned: assert property (@(posedge clk) disable iff (!rst_n)
        st_misalign |-> st_be == '0);

    a_r1_byte_store_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
        st_size == 2'b00 |-> $countones(st_be) == 1);

    a_r3_word_store_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (st_size[1] && !st_misalign) |-> (st_wdata == st_data && st_be == '1));

    a_r8_valid_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        ld_req |=> ld_valid);

    a_r8_no_valid_without_req: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_req |=> !ld_valid);

    a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_req && rst_n) |=> ($stable(ld_result) && $stable(ld_misalign)));

    a_r8_misaligned_load_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_misalign) |-> ld_result == '0);

    a_r5_signed_byte_upper_uniform: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req && ld_size == 2'b00 && ld_signed) |=>
            ld_result[DATA_W-1:8] == {(DATA_W-8){ld_result[7]}});
endmodule

bind lsa_lane_aligner lsa_lane_aligner_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .st_size    (st_size),
    .st_data    (st_data),
    .st_wdata   (st_wdata),
    .st_be      (st_be),
    .st_misalign(st_misalign),
    .ld_req     (ld_req),
    .ld_size    (ld_size),
    .ld_signed  (ld_signed),
    .ld_valid   (ld_valid),
    .ld_result  (ld_result),
    .ld_misalign(ld_misalign)
);

// File: tb/tb_lsa_lane_aligner.sv
module tb_lsa_lane_aligner;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  st_addr_lo = '0;
    logic [1:0]  st_size = '0;
    logic [31:0] st_data = '0;
    logic [31:0] st_wdata;
    logic [3:0]  st_be;
    logic        st_misalign;
    logic        ld_req = 1'b0;
    logic [1:0]  ld_addr_lo = '0;
    logic [1:0]  ld_size = '0;
    logic        ld_signed = 1'b0;
    logic [31:0] ld_rdata = '0;
    logic        ld_valid;
    logic [31:0] ld_result;
    logic        ld_misalign;

    int checks = 0;
    int failures = 0;
    logic [31:0] m_res = '0;
    logic        m_mis = 1'b0;

    always #5 clk = ~clk;

    lsa_lane_aligner dut (.*);

    function automatic bit is_mis(input logic [1:0] sz, input logic [1:0] a);
        int ai = int'(a);
        if (sz == 2'b00) return 1'b0;
        if (sz == 2'b01) return (ai % 2) != 0;
        return (ai % 4) != 0;
    endfunction

    function automatic string st_tag(input logic [1:0] sz);
        if (sz == 2'b00) return "R1";
        if (sz == 2'b01) return "R2";
        return "R3";
    endfunction

    function automatic string ld_tag(input logic [1:0] sz);
        if (sz == 2'b00) return "R5";
        if (sz == 2'b01) return "R6";
        return "R7";
    endfunction

    function automatic logic [31:0] model_load(input logic [1:0] sz, input logic [1:0] a,
                                               input logic sg, input logic [31:0] mem);
        logic [31:0] v;
        if (is_mis(sz, a)) return 32'h0;
        v = mem >> (int'(a) * 8);
        if (sz == 2'b00) return (sg && v[7]) ? (v | 32'hFFFF_FF00) : (v & 32'h0000_00FF);
        if (sz == 2'b01) return (sg && v[15]) ? (v | 32'hFFFF_0000) : (v & 32'h0000_FFFF);
        return mem;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic sreq, input logic [1:0] sz, input logic [1:0] a,
                        input logic sg, input logic [31:0] d);
        logic [3:0]  e_be;
        logic [31:0] e_wd;
        bit          mis;
        st_addr_lo = a; st_size = sz; st_data = d;
        ld_req = sreq; ld_addr_lo = a; ld_size = sz; ld_signed = sg; ld_rdata = d;
        #1;
        mis = is_mis(sz, a);
        if (sz == 2'b00) begin
            e_wd = {4{d[7:0]}};
            e_be = 4'b0001 << a;
        end else if (sz == 2'b01) begin
            e_wd = {2{d[15:0]}};
            e_be = 4'b0011 << a;
        end else begin
            e_wd = d;
            e_be = 4'b1111;
        end
        if (mis) e_be = 4'b0000;
        chk(st_misalign == mis, "R4", "st_misalign", 32'(st_misalign), 32'(mis));
        chk(st_be == e_be, mis ? "R4" : st_tag(sz), "st_be", 32'(st_be), 32'(e_be));
        if (!mis) chk(st_wdata == e_wd, st_tag(sz), "st_wdata", st_wdata, e_wd);
        if (sreq) begin
            m_res = model_load(sz, a, sg, d);
            m_mis = mis;
        end
        @(posedge clk);
        #1;
        chk(ld_valid == sreq, "R8", "ld_valid", 32'(ld_valid), 32'(sreq));
        chk(ld_misalign == m_mis, "R8", "ld_misalign", 32'(ld_misalign), 32'(m_mis));
        chk(ld_result == m_res, sreq ? (m_mis ? "R8" : ld_tag(sz)) : "R8",
            "ld_result", ld_result, m_res);
    endtask

    initial begin
        #2000000;
        failures++;
        $display("FAIL R8 watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] pats [4];
        pats[0] = 32'h80FF_7F01;
        pats[1] = 32'h7F80_FF00;
        pats[2] = 32'hA5C3_1E96;
        pats[3] = 32'h0000_8000;
        ld_req = 1'b1;
        ld_rdata = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        #1;
        chk(ld_valid == 1'b0, "R9", "reset ld_valid", 32'(ld_valid), 32'h0);
        chk(ld_result == 32'h0, "R9", "reset ld_result", ld_result, 32'h0);
        chk(ld_misalign == 1'b0, "R9", "reset ld_misalign", 32'(ld_misalign), 32'h0);
        ld_req = 1'b0;
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        for (int sz = 0; sz < 4; sz++)
            for (int a = 0; a < 4; a++)
                for (int sg = 0; sg < 2; sg++)
                    for (int p = 0; p < 4; p++) begin
                        step(1'b1, 2'(sz), 2'(a), 1'(sg), pats[p]);
                        if (p == 2) step(1'b0, 2'(sz), 2'(a), 1'(sg), ~pats[p]);
                    end
        for (int n = 0; n < 300; n++) begin
            logic [31:0] r;
            r = $urandom;
            step(1'(r[0] | r[1]), r[3:2], r[5:4], r[6], $urandom);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule